// File: doc/BRIEF.md
# Multi-Cycle 16-bit Processor Core

This block is a compact von Neumann processor for a fixed 16-bit instruction set. Code and data share one memory of 256 sixteen-bit words. The memory is addressed by word with an 8-bit address and starts out all zero. The core keeps an 8-bit program counter, seven general registers R0 to R6 and a 4-bit flag register. Each instruction takes two cycles: one fetches the word at the program counter, and the next decodes, executes and commits it.

A surrounding testbench or loader holds the core in reset and writes the program and its data through a load port. It then releases reset, and execution starts at address 0. After each instruction the core raises a one-cycle trace strobe. The strobe carries the address of that instruction and all eight architectural registers as they stand after it. The core stops on a halt instruction or on an undefined opcode. Once it has stopped, a separate debug read port lets the whole memory be dumped.

Top module: `isa_core`

## Requirements
- R1: While reset is held, trace_valid, halted and illegal are 0, trace_pc is 0 and trace_regs is all zero. After release, execution begins at address 0.
- R2: Opcodes 00000 (add), 00001 (sub) and 00110 (mul) take the destination from bits 8:6 and the sources from bits 5:3 and 2:0. add and mul keep the low 16 bits of the result and set flag V (bit 3) when the result does not fit. When the second source exceeds the first, sub writes 0 and sets V.
- R3: xor (01010), or (01011) and and (01100) use the same fields as add. not (01101) writes the inverse of the register at 2:0 into the register at 5:3. rs (01000) and ls (01001) shift the register at 10:8 by the 8-bit amount at 7:0, and a shift of 16 or more gives 0.
- R4: movi (00010) writes the zero-extended value at 7:0 into the register at 10:8. mov (00011) copies the register at 2:0 into the register at 5:3. Source code 111 reads the flags as they were before this instruction.
- R5: ld (00100) loads the word at address 7:0 into the register at 10:8. st (00101) writes that register to address 7:0. A later fetch or load of that address sees the new value, and so does the debug port.
- R6: div (00111) divides the register at 5:3 by the register at 2:0, putting the quotient in R0 and the remainder in R1. A zero divisor writes 0 to both.
- R7: cmp (01110) compares the registers at 5:3 and 2:0 and sets exactly one of L (bit 2, less), G (bit 1, greater) or E (bit 0, equal).
- R8: Every instruction except add, sub, mul and cmp leaves the flags at 0.
- R9: jmp (01111) always branches to address 7:0. jlt (10000), jgt (10001) and je (10010) branch only when L, G or E respectively was set by the previous instruction. Any other instruction advances the program counter by one, modulo 256.
- R10: Each executed instruction produces exactly one trace_valid pulse of one cycle, two cycles after the previous pulse or after reset release. The pulse carries the instruction's address and the post-execution registers, packed R0 in bits 15:0 through R6 in bits 111:96, with the flags in bits 115:112 and zero above them.
- R11: hlt (10011) is traced. It then raises halted, and no further instruction is fetched, traced or stored until reset.
- R12: Opcodes 10100 to 11111 are traced, write no register, raise halted and raise a sticky illegal output.
- R13: A register write that names code 111 as its destination is discarded, and the flags follow only R2, R7 and R8.
- R14: Words written through the load port while reset is held become the memory contents that the program runs on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the core state |
| load_en | input | 1 | Write enable of the preload port |
| load_addr | input | 8 | Preload word address |
| load_data | input | 16 | Preload word |
| dbg_addr | input | 8 | Debug read address |
| dbg_data | output | 16 | Memory word at dbg_addr (combinational) |
| trace_valid | output | 1 | One-cycle strobe per executed instruction |
| trace_pc | output | 8 | Address of the traced instruction |
| trace_regs | output | 128 | R0..R6 and flags after the traced instruction |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Stop was caused by an undefined opcode |

## Verification
The bench uses the only configuration the instruction set allows: an 8-bit address and 256 words of memory. At that size every program can be preloaded in full and the whole memory compared after each run. A bench-side instruction interpreter checks every trace line, which makes near-exhaustive coverage practical. Directed programs sweep operand pairs at the 16-bit extremes through every arithmetic, shift, compare and branch form. Random instruction streams over all defined opcodes reach field combinations that hand-written programs miss, such as code 111 as an operand, self-modifying stores and wrapping jumps.

// File: rtl/isa_pkg.sv
package isa_pkg;
    localparam int DW      = 16;
    localparam int AW      = 8;
    localparam int NGPR    = 7;
    localparam int FLW     = 4;
    localparam int LAST_OP = 19;

    localparam logic [2:0] FLAGS_SEL = 3'd7;

    localparam int FL_V = 3;
    localparam int FL_L = 2;
    localparam int FL_G = 1;
    localparam int FL_E = 0;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_SUB  = 5'd1,
        OP_MOVI = 5'd2,
        OP_MOV  = 5'd3,
        OP_LD   = 5'd4,
        OP_ST   = 5'd5,
        OP_MUL  = 5'd6,
        OP_DIV  = 5'd7,
        OP_RS   = 5'd8,
        OP_LS   = 5'd9,
        OP_XOR  = 5'd10,
        OP_OR   = 5'd11,
        OP_AND  = 5'd12,
        OP_NOT  = 5'd13,
        OP_CMP  = 5'd14,
        OP_JMP  = 5'd15,
        OP_JLT  = 5'd16,
        OP_JGT  = 5'd17,
        OP_JE   = 5'd18,
        OP_HLT  = 5'd19
    } opcode_e;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_EXEC  = 2'd1,
        ST_HALT  = 2'd2
    } core_st_e;

    typedef struct packed {
        opcode_e    opc;
        logic       legal;
        logic       wr_reg;
        logic       sets_fl;
        logic [2:0] dst;
        logic [2:0] sa;
        logic [2:0] sb;
        logic [7:0] imm;
    } dec_t;

    typedef struct packed {
        core_st_e                  st;
        logic [AW-1:0]             pc;
        logic [DW-1:0]             ir;
        logic [NGPR-1:0][DW-1:0]   regs;
        logic [FLW-1:0]            flags;
        logic                      halted;
        logic                      illegal;
        logic                      tvalid;
        logic [AW-1:0]             tpc;
    } core_q_t;
endpackage

// File: rtl/isa_mem.sv
module isa_mem #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    input  logic [AW-1:0] dbg_addr,
    output logic [DW-1:0] dbg_rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words_q [DEPTH];

    // Contents start cleared; reset of the core leaves them alone.
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            words_q[i] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            words_q[waddr] <= wdata;
        end
    end

    assign rdata     = words_q[raddr];
    assign dbg_rdata = words_q[dbg_addr];
endmodule

// File: rtl/isa_decode.sv
module isa_decode
    import isa_pkg::*;
(
    input  logic [DW-1:0] ir,
    output dec_t          dec
);
    always_comb begin
        dec        = '0;
        dec.opc    = opcode_e'(ir[15:11]);
        dec.imm    = ir[7:0];
        dec.legal  = (ir[15:11] <= 5'(LAST_OP));
        unique case (dec.opc)
            OP_ADD, OP_SUB, OP_MUL: begin
                dec.dst     = ir[8:6];
                dec.sa      = ir[5:3];
                dec.sb      = ir[2:0];
                dec.wr_reg  = 1'b1;
                dec.sets_fl = 1'b1;
            end
            OP_XOR, OP_OR, OP_AND: begin
                dec.dst    = ir[8:6];
                dec.sa     = ir[5:3];
                dec.sb     = ir[2:0];
                dec.wr_reg = 1'b1;
            end
            OP_MOVI, OP_LD: begin
                dec.dst    = ir[10:8];
                dec.wr_reg = 1'b1;
            end
            OP_ST: begin
                dec.sa = ir[10:8];
            end
            OP_RS, OP_LS: begin
                dec.dst    = ir[10:8];
                dec.sa     = ir[10:8];
                dec.wr_reg = 1'b1;
            end
            OP_MOV, OP_NOT: begin
                dec.dst    = ir[5:3];
                dec.sb     = ir[2:0];
                dec.wr_reg = 1'b1;
            end
            OP_CMP: begin
                dec.sa      = ir[5:3];
                dec.sb      = ir[2:0];
                dec.sets_fl = 1'b1;
            end
            OP_DIV: begin
                dec.sa = ir[5:3];
                dec.sb = ir[2:0];
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/isa_alu.sv
module isa_alu
    import isa_pkg::*;
(
    input  opcode_e        opc,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    input  logic [7:0]     imm,
    input  logic [DW-1:0]  rdata,
    output logic [DW-1:0]  res,
    output logic [DW-1:0]  rem,
    output logic [FLW-1:0] fl
);
    logic [DW:0]     sum;
    logic [2*DW-1:0] prod;

    assign sum  = {1'b0, a} + {1'b0, b};
    assign prod = (2*DW)'(a) * (2*DW)'(b);

    always_comb begin
        res = '0;
        rem = '0;
        fl  = '0;
        case (opc)
            OP_ADD: begin
                res      = sum[DW-1:0];
                fl[FL_V] = sum[DW];
            end
            OP_SUB: begin
                if (b > a) begin
                    fl[FL_V] = 1'b1;
                end else begin
                    res = a - b;
                end
            end
            OP_MUL: begin
                res      = prod[DW-1:0];
                fl[FL_V] = |prod[2*DW-1:DW];
            end
            OP_DIV: begin
                if (b != '0) begin
                    res = a / b;
                    rem = a % b;
                end
            end
            OP_RS:   res = a >> imm;
            OP_LS:   res = a << imm;
            OP_XOR:  res = a ^ b;
            OP_OR:   res = a | b;
            OP_AND:  res = a & b;
            OP_NOT:  res = ~b;
            OP_MOVI: res = {{(DW-8){1'b0}}, imm};
            OP_MOV:  res = b;
            OP_LD:   res = rdata;
            OP_CMP: begin
                fl[FL_L] = (a < b);
                fl[FL_G] = (a > b);
                fl[FL_E] = (a == b);
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/isa_core.sv
module isa_core
    import isa_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_en,
    input  logic [7:0]      load_addr,
    input  logic [15:0]     load_data,
    input  logic [7:0]      dbg_addr,
    output logic [15:0]     dbg_data,
    output logic            trace_valid,
    output logic [7:0]      trace_pc,
    output logic [127:0]    trace_regs,
    output logic            halted,
    output logic            illegal
);
    core_q_t        q, d;
    dec_t           dec;
    logic [DW-1:0]  mem_rdata;
    logic [AW-1:0]  mem_raddr;
    logic           core_we;
    logic           mem_we;
    logic [AW-1:0]  mem_waddr;
    logic [DW-1:0]  mem_wdata;
    logic [DW-1:0]  a_val, b_val;
    logic [DW-1:0]  alu_res, alu_rem;
    logic [FLW-1:0] alu_fl;
    logic           take;

    isa_decode u_dec (
        .ir  (q.ir),
        .dec (dec)
    );

    // Operand fetch: code 111 reads as zero except as the mov source.
    always_comb begin
        a_val = '0;
        b_val = '0;
        for (int i = 0; i < NGPR; i++) begin
            if (dec.sa == 3'(i)) a_val = q.regs[i];
            if (dec.sb == 3'(i)) b_val = q.regs[i];
        end
        if (dec.opc == OP_MOV && dec.sb == FLAGS_SEL) begin
            b_val = {{(DW-FLW){1'b0}}, q.flags};
        end
    end

    isa_alu u_alu (
        .opc   (dec.opc),
        .a     (a_val),
        .b     (b_val),
        .imm   (dec.imm),
        .rdata (mem_rdata),
        .res   (alu_res),
        .rem   (alu_rem),
        .fl    (alu_fl)
    );

    // Branch decision uses the flags left by the previous instruction.
    always_comb begin
        case (dec.opc)
            OP_JMP:  take = 1'b1;
            OP_JLT:  take = q.flags[FL_L];
            OP_JGT:  take = q.flags[FL_G];
            OP_JE:   take = q.flags[FL_E];
            default: take = 1'b0;
        endcase
    end

    assign mem_raddr = (q.st == ST_EXEC) ? dec.imm : q.pc;
    assign mem_we    = load_en | core_we;
    assign mem_waddr = load_en ? load_addr : dec.imm;
    assign mem_wdata = load_en ? load_data : a_val;

    isa_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk       (clk),
        .we        (mem_we),
        .waddr     (mem_waddr),
        .wdata     (mem_wdata),
        .raddr     (mem_raddr),
        .rdata     (mem_rdata),
        .dbg_addr  (dbg_addr),
        .dbg_rdata (dbg_data)
    );

    always_comb begin
        d        = q;
        d.tvalid = 1'b0;
        core_we  = 1'b0;
        case (q.st)
            ST_FETCH: begin
                d.ir = mem_rdata;
                d.st = ST_EXEC;
            end
            ST_EXEC: begin
                d.tvalid = 1'b1;
                d.tpc    = q.pc;
                d.flags  = alu_fl;
                d.st     = ST_FETCH;
                d.pc     = q.pc + 1'b1;
                if (dec.wr_reg) begin
                    for (int i = 0; i < NGPR; i++) begin
                        if (dec.dst == 3'(i)) d.regs[i] = alu_res;
                    end
                end
                if (dec.opc == OP_DIV) begin
                    d.regs[0] = alu_res;
                    d.regs[1] = alu_rem;
                end
                if (take) begin
                    d.pc = dec.imm;
                end
                if (dec.opc == OP_ST) begin
                    core_we = 1'b1;
                end
                if (!dec.legal || dec.opc == OP_HLT) begin
                    d.st      = ST_HALT;
                    d.halted  = 1'b1;
                    d.illegal = !dec.legal;
                    d.pc      = q.pc;
                end
            end
            default: begin
                d.st = ST_HALT;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign trace_valid = q.tvalid;
    assign trace_pc    = q.tpc;
    assign trace_regs  = {{(DW-FLW){1'b0}}, q.flags, q.regs};
    assign halted      = q.halted;
    assign illegal     = q.illegal;

    // R2: an underflowing subtract produces zero alongside V.
    assert_sub_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_EXEC && dec.opc == OP_SUB && alu_fl[FL_V]) |-> (alu_res == '0));

    // R7: compare outcomes are mutually exclusive and never mix with V.
    assert_cmp_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q.flags[2:0]) && !(q.flags[FL_V] && (|q.flags[2:0])));

    // R8: non-flag instructions leave the flag register cleared.
    assert_flags_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_EXEC && !dec.sets_fl) |=> (q.flags == '0));

    // R9: the program counter only moves in the execute cycle.
    assert_pc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FETCH) |=> $stable(q.pc));

    // R10: the trace strobe lasts a single cycle.
    assert_trace_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q.tvalid |=> !q.tvalid);

    // R11: halt is sticky and silences the trace.
    assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        q.halted |=> (q.halted && !q.tvalid));

    // R11: no store reaches memory from a halted core.
    assert_halt_no_store_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_HALT) |-> !core_we);

    // R12: an illegal stop is always a halt.
    assert_illegal_halts_R12: assert property (@(posedge clk) disable iff (!rst_n)
        q.illegal |-> q.halted);
endmodule

// File: tb/tb_isa_core.sv
module tb_isa_core;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_en = 1'b0;
    logic [7:0]   load_addr = '0;
    logic [15:0]  load_data = '0;
    logic [7:0]   dbg_addr = '0;
    logic [15:0]  dbg_data;
    logic         trace_valid;
    logic [7:0]   trace_pc;
    logic [127:0] trace_regs;
    logic         halted;
    logic         illegal;

    always #4 clk = ~clk;

    isa_core dut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .dbg_addr(dbg_addr), .dbg_data(dbg_data),
        .trace_valid(trace_valid), .trace_pc(trace_pc), .trace_regs(trace_regs),
        .halted(halted), .illegal(illegal)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // Bench-side architectural model.
    logic [15:0] rm_mem [256];
    logic [15:0] rr [7];
    logic [3:0]  rfl;
    logic [7:0]  rpc;
    bit          rhalt, rill, wr7_g;
    int          pp;
    logic [31:0] seed = 32'h1234_5678;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [135:0] act, input logic [135:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    function automatic logic [15:0] encA(input int op, input int dd, input int s1, input int s2);
        return {5'(op), 2'b00, 3'(dd), 3'(s1), 3'(s2)};
    endfunction
    function automatic logic [15:0] encB(input int op, input int r, input int im);
        return {5'(op), 3'(r), 8'(im)};
    endfunction
    function automatic logic [15:0] encC(input int op, input int r1, input int r2);
        return {5'(op), 5'b0, 3'(r1), 3'(r2)};
    endfunction
    function automatic logic [15:0] encE(input int op, input int ad);
        return {5'(op), 3'b0, 8'(ad)};
    endfunction

    task automatic emit(input logic [15:0] w);
        rm_mem[pp[7:0]] = w;
        pp++;
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 256; i++) rm_mem[i] = '0;
        pp = 0;
    endtask

    task automatic set_val(input int r, input logic [15:0] v);
        emit(encB(2, r, v[15:8]));
        emit(encB(9, r, 8));
        emit(encB(2, 6, v[7:0]));
        emit(encA(11, r, r, 6));
    endtask

    function automatic logic [15:0] rd(input logic [2:0] c);
        return (c == 3'd7) ? 16'h0 : rr[c];
    endfunction

    task automatic put(input logic [2:0] dd, input logic [15:0] v);
        if (dd == 3'd7) wr7_g = 1'b1;
        else rr[dd] = v;
    endtask

    function automatic string req_of(input logic [4:0] op);
        case (op)
            5'd0, 5'd1, 5'd6:                 return "R2";
            5'd8, 5'd9, 5'd10, 5'd11, 5'd12, 5'd13: return "R3";
            5'd2, 5'd3:                       return "R4";
            5'd4, 5'd5:                       return "R5";
            5'd7:                             return "R6";
            5'd14:                            return "R7";
            5'd15, 5'd16, 5'd17, 5'd18:       return "R9";
            5'd19:                            return "R11";
            default:                          return "R12";
        endcase
    endfunction

    task automatic ref_step(output logic [7:0] epc, output logic [127:0] eregs,
                            output logic [4:0] eop);
        logic [15:0] w, x, y;
        logic [2:0]  ra, f1, f2, f3;
        logic [7:0]  im, npc;
        logic [3:0]  ofl, nfl;
        logic [16:0] s;
        logic [31:0] p;
        w = rm_mem[rpc];
        eop = w[15:11]; ra = w[10:8]; im = w[7:0];
        f1 = w[8:6]; f2 = w[5:3]; f3 = w[2:0];
        ofl = rfl; nfl = 4'h0; npc = rpc + 8'd1; epc = rpc; wr7_g = 1'b0;
        x = rd(f2); y = rd(f3);
        case (eop)
            5'd0: begin s = {1'b0, x} + {1'b0, y}; put(f1, s[15:0]); nfl[3] = s[16]; end
            5'd1: begin
                if (y > x) begin put(f1, 16'h0); nfl[3] = 1'b1; end
                else put(f1, x - y);
            end
            5'd2: put(ra, {8'h00, im});
            5'd3: put(f2, (f3 == 3'd7) ? {12'h0, ofl} : rr[f3]);
            5'd4: put(ra, rm_mem[im]);
            5'd5: rm_mem[im] = rd(ra);
            5'd6: begin p = 32'(x) * 32'(y); put(f1, p[15:0]); nfl[3] = |p[31:16]; end
            5'd7: begin
                if (y == 16'h0) begin rr[0] = 16'h0; rr[1] = 16'h0; end
                else begin rr[0] = x / y; rr[1] = x % y; end
            end
            5'd8: put(ra, (im > 8'd15) ? 16'h0 : (rd(ra) >> im));
            5'd9: put(ra, (im > 8'd15) ? 16'h0 : (rd(ra) << im));
            5'd10: put(f1, x ^ y);
            5'd11: put(f1, x | y);
            5'd12: put(f1, x & y);
            5'd13: put(f2, ~y);
            5'd14: nfl = {1'b0, x < y, x > y, x == y};
            5'd15: npc = im;
            5'd16: if (ofl[2]) npc = im;
            5'd17: if (ofl[1]) npc = im;
            5'd18: if (ofl[0]) npc = im;
            5'd19: begin rhalt = 1'b1; npc = rpc; end
            default: begin rhalt = 1'b1; rill = 1'b1; npc = rpc; end
        endcase
        rfl = nfl;
        rpc = npc;
        eregs = '0;
        for (int i = 0; i < 7; i++) eregs[i*16 +: 16] = rr[i];
        eregs[115:112] = rfl;
    endtask

    task automatic run_prog(input int max_steps);
        logic [7:0]   epc;
        logic [127:0] eregs;
        logic [4:0]   eop;
        bit           got, quiet;
        int           gap, bad;
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            load_en = 1'b1; load_addr = 8'(i); load_data = rm_mem[i];
        end
        @(negedge clk);
        load_en = 1'b0;
        // R1: state held in reset
        check(!trace_valid && !halted && !illegal && trace_pc == 8'h0 && trace_regs == '0,
              "R1", "reset outputs",
              {trace_valid, halted, illegal, trace_pc, trace_regs}, '0);
        for (int i = 0; i < 7; i++) rr[i] = 16'h0;
        rfl = 4'h0; rpc = 8'h0; rhalt = 1'b0; rill = 1'b0;
        rst_n = 1'b1;
        for (int st = 0; st < max_steps && !rhalt; st++) begin
            got = 1'b0; gap = 0;
            for (int k = 0; k < 8 && !got; k++) begin
                @(negedge clk);
                gap++;
                if (trace_valid) got = 1'b1;
            end
            check(got && gap == 2, "R10", "trace spacing", 136'(gap), 136'd2);
            if (!got) break;
            ref_step(epc, eregs, eop);
            check(trace_pc == epc, req_of(eop), "trace pc", 136'(trace_pc), 136'(epc));
            check(trace_regs == eregs, req_of(eop), "trace regs", 136'(trace_regs), 136'(eregs));
            if (eop != 5'd0 && eop != 5'd1 && eop != 5'd6 && eop != 5'd14)
                check(trace_regs[127:112] == 16'h0, "R8", "flags cleared",
                      136'(trace_regs[127:112]), 136'd0);
            if (wr7_g)
                check(trace_regs == eregs, "R13", "code 111 write dropped",
                      136'(trace_regs), 136'(eregs));
        end
        if (rhalt) begin
            check(halted && (illegal == rill), rill ? "R12" : "R11", "halt outputs",
                  {134'd0, halted, illegal}, {134'd0, 1'b1, rill});
            quiet = 1'b1;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (trace_valid || !halted) quiet = 1'b0;
            end
            check(quiet, "R11", "silent after halt", 136'(quiet), 136'd1);
        end
        rst_n = 1'b0;
        bad = 0;
        for (int i = 0; i < 256; i++) begin
            dbg_addr = 8'(i);
            #1;
            if (dbg_data !== rm_mem[i]) begin
                if (bad == 0)
                    check(1'b0, "R5 R14", $sformatf("dump word %0d", i),
                          136'(dbg_data), 136'(rm_mem[i]));
                bad++;
            end
        end
        if (bad == 0) check(1'b1, "R5 R14", "memory dump", 136'd0, 136'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R10 watchdog: actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] va [10];
        logic [15:0] vb [10];
        int          sh [10];
        va = '{16'h0000, 16'h0001, 16'hFFFF, 16'hFFFF, 16'h8000,
               16'h0003, 16'h0004, 16'h1234, 16'h0100, 16'h0005};
        vb = '{16'h0000, 16'h0000, 16'h0001, 16'hFFFF, 16'h8000,
               16'h0004, 16'h0003, 16'h00FF, 16'h0100, 16'h0005};
        sh = '{0, 1, 15, 16, 255, 3, 8, 4, 7, 2};

        // Operand sweep through arithmetic, logic, shifts, compares, branches, divide.
        for (int t = 0; t < 10; t++) begin
            clear_prog();
            set_val(1, va[t]);
            set_val(2, vb[t]);
            emit(encA(0, 3, 1, 2)); emit(encC(3, 4, 7));
            emit(encA(1, 3, 1, 2)); emit(encC(3, 4, 7));
            emit(encA(6, 3, 1, 2)); emit(encC(3, 4, 7));
            emit(encA(10, 3, 1, 2)); emit(encA(11, 3, 1, 2));
            emit(encA(12, 3, 1, 2)); emit(encC(13, 4, 1));
            emit(encC(3, 3, 1)); emit(encB(8, 3, sh[t]));
            emit(encC(3, 3, 2)); emit(encB(9, 3, sh[9 - t]));
            emit(encC(14, 1, 2)); emit(encE(16, pp + 2)); emit(encB(2, 5, 8'h11));
            emit(encC(14, 1, 2)); emit(encE(17, pp + 2)); emit(encB(2, 5, 8'h22));
            emit(encC(14, 1, 2)); emit(encE(18, pp + 2)); emit(encB(2, 5, 8'h33));
            emit(encC(14, 1, 2)); emit(encB(2, 5, 8'h01)); emit(encE(18, pp + 2));
            emit(encB(2, 5, 8'h44));
            emit(encC(14, 1, 2)); emit(encC(3, 4, 7));
            emit(encC(7, 1, 2));
            emit(encE(19, 0));
            run_prog(100);
        end

        // Memory traffic and discarded writes to code 111.
        clear_prog();
        rm_mem[201] = 16'hBEEF;
        emit(encB(2, 1, 8'hAB)); emit(encB(9, 1, 4));
        emit(encB(5, 1, 200)); emit(encB(4, 2, 200));
        emit(encB(5, 2, 255)); emit(encB(4, 3, 0));
        emit(encB(4, 5, 201));
        emit(encC(14, 1, 2));
        emit(encB(2, 7, 8'h55));
        emit(encA(0, 7, 1, 1));
        emit(encC(3, 7, 1));
        emit(encC(3, 4, 7));
        emit(encE(19, 0));
        run_prog(40);

        // Program counter wrap through address 255.
        clear_prog();
        emit(encB(2, 1, 1)); emit(encA(0, 2, 2, 1)); emit(encC(14, 2, 1));
        emit(encE(17, 5)); emit(encE(15, 255)); emit(encE(19, 0));
        rm_mem[255] = encB(2, 3, 9);
        run_prog(40);

        // Halt as the very first instruction.
        clear_prog();
        emit(encE(19, 0));
        run_prog(5);

        // Undefined opcodes at both ends of the reserved range.
        clear_prog();
        emit(encB(2, 1, 5)); emit({5'd20, 11'h155}); emit(encB(2, 2, 7));
        run_prog(10);
        clear_prog();
        emit(encC(14, 1, 1)); emit({5'd31, 11'h7FF});
        run_prog(10);

        // Random instruction streams over all defined opcodes.
        for (int t = 0; t < 24; t++) begin
            logic [31:0] r;
            clear_prog();
            for (int i = 0; i < 256; i++) begin
                r = rnd();
                if (i < 160) rm_mem[i] = {5'(r[31:16] % 19), r[10:0]};
                else rm_mem[i] = r[15:0];
            end
            if (t % 4 == 3) rm_mem[60] = encE(19, 0);
            run_prog(80);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule